// File: doc/BRIEF.md
# Single-Wire Half-Duplex UART Transceiver

This block runs a UART over one shared open-drain wire. Transmit and receive use the same wire. Toward the core it offers two byte queues with valid/ready handshakes, one for transmit and one for receive. Toward the pad it has three signals: an output-enable, a pad output value that is always zero, and the pad input.

To send a zero, the block switches the pad driver on. To send a one or to idle, it switches the driver off and lets the external pull-up hold the wire high. Incoming frames pass through a two-flop synchronizer and are then sampled with an oversampling counter.

A direction request from the core decides who owns the wire:
- While the request is high, the block serializes queued bytes and keeps its receiver off.
- When the request falls, the block sends every byte still queued. It then waits a guard interval before it releases ownership and turns the receiver back on.

Two stall timers watch the queue handshakes and pulse a timeout when a transfer has stalled for too long.

Top module: `sw_uart`

## Requirements
- R1: After synchronous reset the block is listening (`listening`=1), `pad_oe`=0, `rx_valid`=0, `tx_ready`=1, and no error or timeout pulse is present. `pad_out` is always 0.
- R2: One oversampling tick occurs every CLK_HZ/(OVS*BAUD) clocks, and one bit lasts OVS ticks. With the defaults OVS=8 and BAUD=115200, a bit whose divider is 2 lasts exactly 16 clocks.
- R3: A transmitted frame has four parts, in this order:
  - a start bit with `pad_oe`=1;
  - eight data bits, least significant first, where a 0 gives `pad_oe`=1 and a 1 gives `pad_oe`=0;
  - a stop bit with `pad_oe`=0;
  - idle, with `pad_oe`=0.
  A frame begins only while transmit ownership is held.
- R4: While listening, the receiver arms on a low wire. It samples the first data bit 1.5 bit periods after it detects the low, then one sample per bit period for eight bits, least significant first. If the stop position is high, the byte is pushed into the receive queue.
- R5: If the stop position is low, the byte is dropped and `frame_err` pulses for exactly one clock. The receiver does not re-arm until the wire has returned high.
- R6: The receiver captures nothing while `listening` is 0. This covers the block's own frames and any frame driven onto the wire during that time.
- R7: After `dir_tx` falls, `listening` stays 0 until the transmit queue is empty and a further 11 bit periods have passed. The pad is released whenever `listening` is 1.
- R8: The transmit queue holds 8 bytes and sends them in arrival order. `tx_ready` is 0 while the queue is full.
- R9: `tx_timeout` pulses for one clock after TIMEOUT_MS millisecond ticks have arrived while `tx_valid`=1 and `tx_ready`=0. No pulse comes before that count.
- R10: `rx_timeout` pulses for one clock after TIMEOUT_MS millisecond ticks have arrived while `rx_ready`=1 and `rx_valid`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_ms | input | 1 | One-clock pulse every millisecond, drives the stall timers |
| dir_tx | input | 1 | Request to own the wire and transmit |
| tx_data | input | 8 | Byte offered to the transmit queue |
| tx_valid | input | 1 | `tx_data` is valid |
| tx_ready | output | 1 | Transmit queue can accept a byte |
| rx_data | output | 8 | Oldest received byte |
| rx_valid | output | 1 | Receive queue holds a byte |
| rx_ready | input | 1 | Core takes the byte on `rx_data` |
| tx_timeout | output | 1 | One-clock pulse when the transmit handshake has stalled too long |
| rx_timeout | output | 1 | One-clock pulse when the receive handshake has stalled too long |
| frame_err | output | 1 | One-clock pulse when a frame has a low stop position |
| listening | output | 1 | Wire released and receiver enabled |
| pad_oe | output | 1 | Pad driver enable, 1 pulls the wire low |
| pad_out | output | 1 | Pad output value, constant 0 |
| pad_in | input | 1 | Pad input, asynchronous to `clk` |

## Verification
The timeout assertions assume two things about the core:
- `tick_ms` is a single-clock pulse.
- The core holds `tx_valid` or `rx_ready` steady while it waits on a stalled handshake.

The bench drives those inputs only at falling clock edges and holds them through each stall window. The receive-capture assertion looks two cycles back, because a frame that completes on the cycle ownership changes was legally sampled. The bench changes `dir_tx` only while the wire is idle, or while it is driving a frame of its own that must be ignored. The wire is modelled as a wired-AND of the block's driver and the bench's driver, so the block never sees a level the pull-up could not produce.

// File: rtl/sw_uart_pkg.sv
// Shared types for the single-wire UART.
// Assumes: byte-wide data, ten-bit frames (start, eight data, stop).
package sw_uart_pkg;

    typedef logic [7:0] byte_t;

    // Ownership of the shared wire.
    typedef enum logic [1:0] {
        OWN_LISTEN = 2'd0,
        OWN_TALK   = 2'd1,
        OWN_DRAIN  = 2'd2,
        OWN_GUARD  = 2'd3
    } own_state_t;

    // Receiver progress through a frame.
    typedef enum logic [1:0] {
        RCV_ARM    = 2'd0,
        RCV_BITS   = 2'd1,
        RCV_WAITHI = 2'd2
    } rcv_state_t;

endpackage

// File: rtl/swu_fifo.sv
// Byte queue with valid/ready on both sides.
// Assumes: DEPTH is a power of two. Writes and reads may happen in the same cycle.
module swu_fifo #(
    parameter int W     = 8,
    parameter int DEPTH = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] in_data,
    input  logic         in_valid,
    output logic         in_ready,
    output logic [W-1:0] out_data,
    output logic         out_valid,
    input  logic         out_ready
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);
    localparam logic [CW-1:0] FULL = CW'(DEPTH);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wptr, rptr;
    logic [CW-1:0] count;
    logic          wr, rd;

    assign in_ready  = (count != FULL);
    assign out_valid = (count != '0);
    assign out_data  = mem[rptr];
    assign wr        = in_valid && in_ready;
    assign rd        = out_valid && out_ready;

    // Storage write, no reset needed on data.
    always_ff @(posedge clk) begin
        if (wr) mem[wptr] <= in_data;
    end

    // Pointer and occupancy bookkeeping.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wptr  <= '0;
            rptr  <= '0;
            count <= '0;
        end else begin
            if (wr) wptr <= wptr + 1'b1;
            if (rd) rptr <= rptr + 1'b1;
            if (wr && !rd)      count <= count + 1'b1;
            else if (rd && !wr) count <= count - 1'b1;
        end
    end
endmodule

// File: rtl/swu_tx.sv
// Frame serializer that drives the wire only by enabling the pad driver.
// Assumes: tick is a single-cycle enable at OVS ticks per bit. A frame starts
// on a tick when allowed, and once started it always runs to its stop bit.
module swu_tx #(
    parameter int OVS = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic       allow,
    input  logic [7:0] q_data,
    input  logic       q_valid,
    output logic       q_pop,
    output logic       oe
);
    localparam int TCW = (OVS > 1) ? $clog2(OVS) : 1;
    localparam logic [TCW-1:0] TLAST = TCW'(OVS - 1);

    logic [8:0]     sh;     // {stop, data} still to send
    logic [3:0]     bitn;   // 0 start, 1..8 data, 9 stop
    logic [TCW-1:0] tcnt;
    logic           busy;

    assign q_pop = tick && !busy && allow && q_valid;

    // Frame sequencing: load on pop, advance one bit per OVS ticks.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy <= 1'b0;
            oe   <= 1'b0;
            sh   <= '1;
            bitn <= '0;
            tcnt <= '0;
        end else if (q_pop) begin
            busy <= 1'b1;
            oe   <= 1'b1;
            sh   <= {1'b1, q_data};
            bitn <= '0;
            tcnt <= '0;
        end else if (busy && tick) begin
            if (tcnt == TLAST) begin
                tcnt <= '0;
                if (bitn == 4'd9) begin
                    busy <= 1'b0;
                    oe   <= 1'b0;
                end else begin
                    bitn <= bitn + 4'd1;
                    oe   <= ~sh[0];
                    sh   <= {1'b1, sh[8:1]};
                end
            end else begin
                tcnt <= tcnt + 1'b1;
            end
        end
    end
endmodule

// File: rtl/swu_rx.sv
// Frame deserializer with stop-bit check and framing-error recovery.
// Assumes: line is already synchronized; enable low forces the receiver back
// to its armed state and discards any partial frame.
module swu_rx #(
    parameter int OVS = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic       enable,
    input  logic       line,
    output logic [7:0] push_data,
    output logic       push,
    output logic       ferr
);
    import sw_uart_pkg::*;

    localparam int CW = $clog2(OVS + OVS / 2);
    localparam logic [CW-1:0] FIRST_WAIT = CW'(OVS + OVS / 2 - 1);
    localparam logic [CW-1:0] NEXT_WAIT  = CW'(OVS - 1);

    rcv_state_t    st;
    logic [CW-1:0] cnt;
    logic [3:0]    bitn;   // 0..7 data, 8 stop
    logic [7:0]    sh;

    assign push_data = sh;

    // Arm, sample at mid-bit, check stop, recover from framing errors.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st   <= RCV_ARM;
            cnt  <= '0;
            bitn <= '0;
            sh   <= '0;
            push <= 1'b0;
            ferr <= 1'b0;
        end else begin
            push <= 1'b0;
            ferr <= 1'b0;
            if (!enable) begin
                st   <= RCV_ARM;
                cnt  <= '0;
                bitn <= '0;
            end else if (tick) begin
                case (st)
                    RCV_ARM: begin
                        if (!line) begin
                            st   <= RCV_BITS;
                            cnt  <= FIRST_WAIT;
                            bitn <= '0;
                        end
                    end
                    RCV_BITS: begin
                        if (cnt != '0) begin
                            cnt <= cnt - 1'b1;
                        end else if (bitn != 4'd8) begin
                            sh   <= {line, sh[7:1]};
                            bitn <= bitn + 4'd1;
                            cnt  <= NEXT_WAIT;
                        end else if (line) begin
                            push <= 1'b1;
                            st   <= RCV_ARM;
                        end else begin
                            ferr <= 1'b1;
                            st   <= RCV_WAITHI;
                        end
                    end
                    RCV_WAITHI: begin
                        if (line) st <= RCV_ARM;
                    end
                    default: st <= RCV_ARM;
                endcase
            end
        end
    end
endmodule

// File: rtl/swu_own.sv
// Wire ownership control: talk on request, drain the queue, hold a guard
// interval, then hand the wire back to the receiver.
// Assumes: txq_empty reflects the transmit queue occupancy of this cycle.
module swu_own #(
    parameter int GUARD_TICKS = 88
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic dir_tx,
    input  logic txq_empty,
    output logic listening,
    output logic tx_allow
);
    import sw_uart_pkg::*;

    localparam int GW = $clog2(GUARD_TICKS + 1);
    localparam logic [GW-1:0] GLAST = GW'(GUARD_TICKS - 1);

    own_state_t    st;
    logic [GW-1:0] gcnt;

    assign listening = (st == OWN_LISTEN);
    assign tx_allow  = (st == OWN_TALK) || (st == OWN_DRAIN);

    // Ownership sequencing with the guard counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st   <= OWN_LISTEN;
            gcnt <= '0;
        end else begin
            case (st)
                OWN_LISTEN: if (dir_tx) st <= OWN_TALK;
                OWN_TALK:   if (!dir_tx) st <= OWN_DRAIN;
                OWN_DRAIN: begin
                    if (dir_tx) begin
                        st <= OWN_TALK;
                    end else if (txq_empty) begin
                        st   <= OWN_GUARD;
                        gcnt <= '0;
                    end
                end
                OWN_GUARD: begin
                    if (dir_tx) begin
                        st <= OWN_TALK;
                    end else if (tick) begin
                        if (gcnt == GLAST) st <= OWN_LISTEN;
                        else               gcnt <= gcnt + 1'b1;
                    end
                end
                default: st <= OWN_LISTEN;
            endcase
        end
    end
endmodule

// File: rtl/swu_stall_timer.sv
// Counts millisecond ticks while a handshake is stalled and pulses on expiry.
// Assumes: ms_tick is a one-cycle pulse. Any cycle without a stall clears the count.
module swu_stall_timer #(
    parameter int LIMIT = 20
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ms_tick,
    input  logic stalled,
    output logic expired
);
    localparam int CW = $clog2(LIMIT + 1);
    localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

    logic [CW-1:0] cnt;

    // Stall duration count with single-cycle expiry pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt     <= '0;
            expired <= 1'b0;
        end else begin
            expired <= 1'b0;
            if (!stalled) begin
                cnt <= '0;
            end else if (ms_tick) begin
                if (cnt == LAST) begin
                    cnt     <= '0;
                    expired <= 1'b1;
                end else begin
                    cnt <= cnt + 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/sw_uart.sv
// Single-wire half-duplex UART: two byte queues, serializer, deserializer,
// ownership control and two handshake stall timers.
// Assumes: pad_in sees the wired-AND of this driver and others, with an
// external pull-up. CLK_HZ is a multiple of OVS*BAUD or close to one.
module sw_uart #(
    parameter int CLK_HZ     = 100_000_000,
    parameter int BAUD       = 115_200,
    parameter int OVS        = 8,
    parameter int DEPTH      = 8,
    parameter int TIMEOUT_MS = 20,
    parameter int GUARD_BITS = 11
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick_ms,
    input  logic       dir_tx,
    input  logic [7:0] tx_data,
    input  logic       tx_valid,
    output logic       tx_ready,
    output logic [7:0] rx_data,
    output logic       rx_valid,
    input  logic       rx_ready,
    output logic       tx_timeout,
    output logic       rx_timeout,
    output logic       frame_err,
    output logic       listening,
    output logic       pad_oe,
    output logic       pad_out,
    input  logic       pad_in
);
    import sw_uart_pkg::*;

    localparam int DIV_RAW  = CLK_HZ / (OVS * BAUD);
    localparam int TICK_DIV = (DIV_RAW < 1) ? 1 : DIV_RAW;
    localparam int DW       = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
    localparam logic [DW-1:0] DLAST = DW'(TICK_DIV - 1);
    localparam int GUARD_TICKS = GUARD_BITS * OVS;

    logic [1:0]  sync_q;
    logic        line;
    logic [DW-1:0] dcnt;
    logic        tick;

    byte_t       txq_data;
    logic        txq_valid, txq_pop;
    byte_t       rcv_data;
    logic        rcv_push;
    logic        rxq_in_ready;
    logic        tx_allow;
    logic [1:0]  stalled, expired;

    assign pad_out = 1'b0;
    assign line    = sync_q[1];

    // Two-flop synchronizer for the asynchronous pad input.
    always_ff @(posedge clk) begin
        if (!rst_n) sync_q <= 2'b11;
        else        sync_q <= {sync_q[0], pad_in};
    end

    // Oversampling tick divider.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dcnt <= '0;
            tick <= 1'b0;
        end else begin
            tick <= (dcnt == DLAST);
            dcnt <= (dcnt == DLAST) ? '0 : dcnt + 1'b1;
        end
    end

    swu_fifo #(.W(8), .DEPTH(DEPTH)) u_txq (
        .clk(clk), .rst_n(rst_n),
        .in_data(tx_data), .in_valid(tx_valid), .in_ready(tx_ready),
        .out_data(txq_data), .out_valid(txq_valid), .out_ready(txq_pop)
    );

    swu_fifo #(.W(8), .DEPTH(DEPTH)) u_rxq (
        .clk(clk), .rst_n(rst_n),
        .in_data(rcv_data), .in_valid(rcv_push), .in_ready(rxq_in_ready),
        .out_data(rx_data), .out_valid(rx_valid), .out_ready(rx_ready)
    );

    swu_own #(.GUARD_TICKS(GUARD_TICKS)) u_own (
        .clk(clk), .rst_n(rst_n), .tick(tick), .dir_tx(dir_tx),
        .txq_empty(!txq_valid), .listening(listening), .tx_allow(tx_allow)
    );

    swu_tx #(.OVS(OVS)) u_tx (
        .clk(clk), .rst_n(rst_n), .tick(tick), .allow(tx_allow),
        .q_data(txq_data), .q_valid(txq_valid), .q_pop(txq_pop), .oe(pad_oe)
    );

    swu_rx #(.OVS(OVS)) u_rx (
        .clk(clk), .rst_n(rst_n), .tick(tick), .enable(listening),
        .line(line), .push_data(rcv_data), .push(rcv_push), .ferr(frame_err)
    );

    // A byte arriving at a full receive queue is dropped; rxq_in_ready only gates the write.
    assign stalled[0] = tx_valid && !tx_ready;
    assign stalled[1] = rx_ready && !rx_valid;

    for (genvar g = 0; g < 2; g++) begin : g_timer
        swu_stall_timer #(.LIMIT(TIMEOUT_MS)) u_tmr (
            .clk(clk), .rst_n(rst_n), .ms_tick(tick_ms),
            .stalled(stalled[g]), .expired(expired[g])
        );
    end

    assign tx_timeout = expired[0];
    assign rx_timeout = expired[1];
endmodule

// File: rtl/swu_checks.sv
// Temporal checks on the single-wire UART ports, bound to every sw_uart.
// Assumes: tick_ms is a single-cycle pulse; handshake inputs held while waiting.
module swu_checks (
    input logic clk,
    input logic rst_n,
    input logic tx_valid,
    input logic tx_ready,
    input logic rx_valid,
    input logic rx_ready,
    input logic tx_timeout,
    input logic rx_timeout,
    input logic frame_err,
    input logic listening,
    input logic pad_oe
);
    assert_released_when_listening_R7: assert property (@(posedge clk) disable iff (!rst_n)
        listening |-> !pad_oe);

    assert_ferr_single_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
        frame_err |=> !frame_err);

    assert_capture_only_listening_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rx_valid) |-> $past(listening, 2));

    assert_tx_timeout_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
        tx_timeout |-> $past(tx_valid && !tx_ready));

    assert_rx_timeout_cause_R10: assert property (@(posedge clk) disable iff (!rst_n)
        rx_timeout |-> $past(rx_ready && !rx_valid));

    assert_timeout_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        tx_timeout |=> !tx_timeout);
endmodule

bind sw_uart swu_checks u_checks (
    .clk(clk), .rst_n(rst_n),
    .tx_valid(tx_valid), .tx_ready(tx_ready),
    .rx_valid(rx_valid), .rx_ready(rx_ready),
    .tx_timeout(tx_timeout), .rx_timeout(rx_timeout),
    .frame_err(frame_err), .listening(listening), .pad_oe(pad_oe)
);

// File: tb/tb_sw_uart.sv
// Bench for sw_uart with a small divider (two clocks per tick, 16 clocks per bit).
module tb_sw_uart;
    localparam int BITCLK = 16;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic       rst_n = 1'b0;
    logic       tick_ms = 1'b0;
    logic       dir_tx = 1'b0;
    logic [7:0] tx_data = 8'h00;
    logic       tx_valid = 1'b0;
    logic       tx_ready;
    logic [7:0] rx_data;
    logic       rx_valid;
    logic       rx_ready = 1'b0;
    logic       tx_timeout, rx_timeout, frame_err, listening;
    logic       pad_oe, pad_out, pad_in;
    logic       bench_n = 1'b1;

    assign pad_in = bench_n & ~pad_oe;

    sw_uart #(.CLK_HZ(16), .BAUD(1), .OVS(8), .DEPTH(8),
              .TIMEOUT_MS(3), .GUARD_BITS(11)) dut (
        .clk(clk), .rst_n(rst_n), .tick_ms(tick_ms), .dir_tx(dir_tx),
        .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready),
        .rx_data(rx_data), .rx_valid(rx_valid), .rx_ready(rx_ready),
        .tx_timeout(tx_timeout), .rx_timeout(rx_timeout),
        .frame_err(frame_err), .listening(listening),
        .pad_oe(pad_oe), .pad_out(pad_out), .pad_in(pad_in)
    );

    int cyc = 0;
    int n_chk = 0, n_fail = 0;
    int ferr_cnt = 0, txto_cnt = 0, rxto_cnt = 0;

    always @(posedge clk) cyc <= cyc + 1;

    always @(negedge clk) begin
        if (rst_n) begin
            if (frame_err)  ferr_cnt <= ferr_cnt + 1;
            if (tx_timeout) txto_cnt <= txto_cnt + 1;
            if (rx_timeout) rxto_cnt <= rxto_cnt + 1;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic push(input logic [7:0] b);
        forever begin
            @(negedge clk);
            if (tx_ready) begin
                tx_data  = b;
                tx_valid = 1'b1;
                @(negedge clk);
                tx_valid = 1'b0;
                break;
            end
        end
    endtask

    task automatic pop(output logic [7:0] d, output bit v);
        @(negedge clk);
        v = rx_valid;
        d = rx_data;
        if (v) begin
            rx_ready = 1'b1;
            @(negedge clk);
            rx_ready = 1'b0;
        end
    endtask

    task automatic send_frame(input logic [7:0] b, input bit stopv, input int hold);
        @(negedge clk);
        bench_n = 1'b0;
        repeat (BITCLK) @(negedge clk);
        for (int i = 0; i < 8; i++) begin
            bench_n = b[i];
            repeat (BITCLK) @(negedge clk);
        end
        bench_n = stopv;
        repeat (BITCLK + hold) @(negedge clk);
        bench_n = 1'b1;
    endtask

    task automatic capture(output logic [7:0] d, output bit stop_ok, output int t0);
        int w;
        w = 0;
        d = 8'h00;
        stop_ok = 1'b0;
        t0 = 0;
        while (!pad_oe && w < 3000) begin
            @(negedge clk);
            w++;
        end
        t0 = cyc;
        repeat (BITCLK / 2) @(negedge clk);
        for (int i = 0; i < 8; i++) begin
            repeat (BITCLK) @(negedge clk);
            d[i] = ~pad_oe;
        end
        repeat (BITCLK) @(negedge clk);
        stop_ok = !pad_oe;
    endtask

    task automatic wait_listen(output int t, output bit oe_quiet);
        int w;
        w = 0;
        oe_quiet = 1'b1;
        @(negedge clk);
        while (!listening && w < 2000) begin
            if (pad_oe) oe_quiet = 1'b0;
            @(negedge clk);
            w++;
        end
        t = cyc;
    endtask

    task automatic ms_pulse();
        @(negedge clk);
        tick_ms = 1'b1;
        @(negedge clk);
        tick_ms = 1'b0;
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual=%0d expected=%0d", cyc, 190000);
        summary();
    end

    initial begin
        logic [7:0] d;
        bit v, s, q;
        int t0, t1, hi;

        repeat (5) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(pad_oe == 1'b0,    "R1 pad_oe", pad_oe, 0);
        chk(pad_out == 1'b0,   "R1 pad_out", pad_out, 0);
        chk(listening == 1'b1, "R1 listening", listening, 1);
        chk(rx_valid == 1'b0,  "R1 rx_valid", rx_valid, 0);
        chk(tx_ready == 1'b1,  "R1 tx_ready", tx_ready, 1);
        chk(frame_err == 1'b0, "R1 frame_err", frame_err, 0);

        // R4 receive every byte value
        for (int b = 0; b < 256; b++) begin
            send_frame(8'(b), 1'b1, 0);
            repeat (BITCLK) @(negedge clk);
            pop(d, v);
            chk(v && d == 8'(b), "R4 rx byte", {23'd0, v, d}, 256 + b);
        end
        chk(ferr_cnt == 0, "R4 no framing error", ferr_cnt, 0);

        // R5 low stop: drop, one pulse, wait for high before re-arm
        send_frame(8'h55, 1'b0, 40);
        repeat (200) @(negedge clk);
        chk(ferr_cnt == 1, "R5 frame_err count", ferr_cnt, 1);
        pop(d, v);
        chk(!v, "R5 bad byte dropped", v, 0);
        send_frame(8'hA3, 1'b1, 0);
        repeat (BITCLK) @(negedge clk);
        pop(d, v);
        chk(v && d == 8'hA3, "R5 recovery byte", {23'd0, v, d}, 256 + 8'hA3);
        chk(ferr_cnt == 1, "R5 single error", ferr_cnt, 1);

        // R6 frame on the wire while owning it is ignored
        @(negedge clk);
        dir_tx = 1'b1;
        repeat (4) @(negedge clk);
        chk(!listening, "R6 talk leaves listen", listening, 0);
        send_frame(8'h3C, 1'b1, 0);
        dir_tx = 1'b0;
        wait_listen(t1, q);
        repeat (BITCLK) @(negedge clk);
        pop(d, v);
        chk(!v, "R6 foreign frame ignored", v, 0);

        // R3 transmit every byte value
        @(negedge clk);
        dir_tx = 1'b1;
        for (int b = 0; b < 256; b++) begin
            push(8'(b));
            capture(d, s, t0);
            chk(d == 8'(b) && s, "R3 tx frame", {23'd0, s, d}, 256 + b);
        end
        dir_tx = 1'b0;
        wait_listen(t1, q);
        repeat (BITCLK) @(negedge clk);
        chk(!rx_valid, "R6 own frames not captured", rx_valid, 0);

        // R2 bit length: 0xFF gives only the start bit low
        @(negedge clk);
        dir_tx = 1'b1;
        push(8'hFF);
        while (!pad_oe) @(negedge clk);
        hi = 0;
        while (pad_oe) begin
            hi++;
            @(negedge clk);
        end
        chk(hi == BITCLK, "R2 bit length", hi, BITCLK);
        dir_tx = 1'b0;
        wait_listen(t1, q);

        // R7 turnaround guard after the last queued byte
        @(negedge clk);
        dir_tx = 1'b1;
        push(8'h5A);
        push(8'hC3);
        @(negedge clk);
        dir_tx = 1'b0;
        capture(d, s, t0);
        chk(d == 8'h5A && s, "R7 first drained byte", d, 8'h5A);
        capture(d, s, t0);
        chk(d == 8'hC3 && s, "R7 last drained byte", d, 8'hC3);
        wait_listen(t1, q);
        chk((t1 - t0) >= 174 && (t1 - t0) <= 178, "R7 guard length", t1 - t0, 176);
        chk(q, "R7 released during guard", q, 1);

        // R8 queue depth and order, R9 transmit stall timeout
        for (int i = 0; i < 8; i++) push(8'(8'h10 + i));
        @(negedge clk);
        chk(!tx_ready, "R8 full after 8", tx_ready, 0);
        tx_data  = 8'hEE;
        tx_valid = 1'b1;
        ms_pulse();
        ms_pulse();
        @(negedge clk);
        chk(txto_cnt == 0, "R9 no early timeout", txto_cnt, 0);
        ms_pulse();
        repeat (2) @(negedge clk);
        chk(txto_cnt == 1, "R9 timeout pulse", txto_cnt, 1);
        tx_valid = 1'b0;
        dir_tx = 1'b1;
        for (int i = 0; i < 8; i++) begin
            capture(d, s, t0);
            chk(d == 8'(8'h10 + i) && s, "R8 order", d, 8'h10 + i);
        end
        dir_tx = 1'b0;
        wait_listen(t1, q);

        // R10 receive stall timeout
        @(negedge clk);
        rx_ready = 1'b1;
        ms_pulse();
        ms_pulse();
        @(negedge clk);
        chk(rxto_cnt == 0, "R10 no early timeout", rxto_cnt, 0);
        ms_pulse();
        repeat (2) @(negedge clk);
        chk(rxto_cnt == 1, "R10 timeout pulse", rxto_cnt, 1);
        rx_ready = 1'b0;
        chk(txto_cnt == 1, "R9 no stray timeout", txto_cnt, 1);

        summary();
    end
endmodule